// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block links a simple request/response bus to an 8-bit parallel NOR flash with 4M locations and a 22-bit address. It drives the flash strobes and the data-pin direction. It stretches every flash access over a fixed number of system-clock cycles, so a slow 70 ns part can run beside a much faster system clock. Plain requests become one flash read or one flash write.

A command request makes the block run a complete command on its own. It writes the two-step unlock prefix, then the caller's command byte, then reads the caller's address, and finally writes the return-to-array byte. One command request, with command byte 0x90 and address 0x002, therefore returns the device identifier.

Requests use valid/ready. The request is taken on the rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the whole flash sequence has finished and any read result has been taken, so low ready acts as the bus wait signal. A read result is offered on `resp_valid`/`resp_data` and is held unchanged until `resp_ready` is seen high at a rising edge. A write produces no response.

Top module: `nor_cmd_seq`

## Requirements
- R1: From the first rising edge after reset release, `fl_ce_n` is 0 and `fl_rst_n` is 1 on every cycle.
- R2: After reset, `req_ready`=1, `resp_valid`=0, `fl_oe_n`=1, `fl_we_n`=1 and `fl_dq_oe`=0.
- R3: A plain read (req_write=0, req_cmd=0) holds `fl_oe_n` low for ACCESS_CYC cycles with `fl_dq_oe`=0, and samples `fl_dq_i` at the end of the last of those cycles. `resp_valid` rises ACCESS_CYC+1 cycles after the accepting edge and carries that byte.
- R4: A plain write (req_write=1, req_cmd=0) drives `req_addr`/`req_wdata` with `fl_dq_oe`=1. `fl_we_n` falls only after address and data have been stable for SETTLE_CYC cycles, stays low for PULSE_CYC cycles, and rises while address and data are still unchanged. `req_ready` returns SETTLE_CYC+PULSE_CYC+2 cycles after the accepting edge.
- R5: A command request (req_cmd=1) performs these flash writes in order: 0xAA to address 0xAAA, 0x55 to 0x555, then `req_wdata` to 0xAAA. It then reads `req_addr` and finally writes 0xF0 to address 0. The read byte is returned 4*(SETTLE_CYC+PULSE_CYC+2)+ACCESS_CYC+1 cycles after acceptance.
- R6: Between two flash writes, `fl_we_n` stays high for at least SETTLE_CYC cycles.
- R7: When req_cmd=1, the value of req_write is ignored: the command sequence runs and a response is returned.
- R8: `req_ready` is low while a sequence runs or a response waits. A request held valid in that time is accepted only once ready returns.
- R9: Once `resp_valid` is high, it and `resp_data` stay unchanged until an edge with `resp_ready`=1.
- R10: `fl_oe_n` low and `fl_dq_oe` high never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (low = wait) |
| req_write | input | 1 | 1 = plain write, 0 = read |
| req_cmd | input | 1 | 1 = run unlock command sequence |
| req_addr | input | ADDR_W | Flash byte address |
| req_wdata | input | DATA_W | Write byte, or command byte when req_cmd=1 |
| resp_valid | output | 1 | Read result present |
| resp_ready | input | 1 | Read result taken |
| resp_data | output | DATA_W | Read result byte |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_o | output | DATA_W | Data towards flash |
| fl_dq_oe | output | 1 | 1 = drive data pins, 0 = high impedance |
| fl_dq_i | input | DATA_W | Data from flash pins |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_rst_n | output | 1 | Flash reset, active low |

## Verification
Plain reads at a low address and at the top address check the access stretch and show that the sampled byte depends on the address. A plain write checks the settle, pulse and hold windows. Command requests are tried with the identify byte 0x90, with another byte, and with req_write also set. These runs tell apart the identifier, a plain array read and a wrong unlock order, and reads after a command confirm the return to array mode. A command whose result is withheld from the caller, with a second request queued behind it, checks the response hold and the back-pressure on requests.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    E_IDLE   = 3'd0,
    E_WSETUP = 3'd1,
    E_WPULSE = 3'd2,
    E_WHOLD  = 3'd3,
    E_RACC   = 3'd4
  } eng_state_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_RUN  = 2'd1,
    C_RESP = 2'd2
  } ctl_state_e;

  localparam int UNLOCK_ADDR_A = 'hAAA;
  localparam int UNLOCK_ADDR_B = 'h555;
  localparam int UNLOCK_BYTE_A = 'hAA;
  localparam int UNLOCK_BYTE_B = 'h55;
  localparam int ARRAY_RET_ADDR = 'h000;
  localparam int ARRAY_RET_BYTE = 'hF0;
  localparam int CMD_OP_COUNT  = 5;

endpackage

// File: rtl/nor_op_engine.sv
module nor_op_engine
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 2,
  parameter int PULSE_CYC  = 2,
  parameter int ACCESS_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              op_idle,
  output logic              op_done,
  output logic [DATA_W-1:0] op_rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_i,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int MAX_SP = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int MAXC   = (MAX_SP > ACCESS_CYC) ? MAX_SP : ACCESS_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] PUL_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MAXC);

  eng_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          cnt <= '0;
          if (op_start) begin
            addr_q <= op_addr;
            data_q <= op_wdata;
            st     <= op_write ? E_WSETUP : E_RACC;
          end
        end
        E_WSETUP: begin
          if (cnt == SET_LAST) begin
            cnt <= '0;
            st  <= E_WPULSE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_WPULSE: begin
          if (cnt == PUL_LAST) begin
            cnt <= '0;
            st  <= E_WHOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_WHOLD: begin
          st <= E_IDLE;
        end
        E_RACC: begin
          if (cnt == ACC_LAST) begin
            cnt <= '0;
            st  <= E_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // pin decode straight from registered state
  assign op_idle  = (st == E_IDLE);
  assign fl_addr  = addr_q;
  assign fl_dq_o  = data_q;
  assign fl_dq_oe = (st == E_WSETUP) || (st == E_WPULSE) || (st == E_WHOLD);
  assign fl_we_n  = (st != E_WPULSE);
  assign fl_oe_n  = (st != E_RACC);
  assign op_done  = (st == E_WHOLD) || ((st == E_RACC) && (cnt == ACC_LAST));
  assign op_rdata = fl_dq_i;

  // write-enable high-time tracker for the gap check
  logic [CNT_W-1:0] we_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_hi_cnt <= CNT_SAT;
    end else if (!fl_we_n) begin
      we_hi_cnt <= '0;
    end else if (we_hi_cnt != CNT_SAT) begin
      we_hi_cnt <= we_hi_cnt + 1'b1;
    end
  end

  assert_we_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_o) && fl_dq_oe));

  assert_we_rise_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_o) && fl_dq_oe));

  assert_we_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> (we_hi_cnt >= CNT_W'(SETTLE_CYC)));

  assert_bus_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_dq_oe && !fl_oe_n));

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic              op_start,
  output logic              op_write,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  input  logic              op_idle,
  input  logic              op_done,
  input  logic [DATA_W-1:0] op_rdata
);

  localparam int STEP_W = $clog2(CMD_OP_COUNT);
  localparam logic [STEP_W-1:0] CMD_LAST = STEP_W'(CMD_OP_COUNT - 1);

  ctl_state_e        cst;
  logic              issued;
  logic [STEP_W-1:0] step;
  logic              cmd_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [STEP_W-1:0] step_last;

  assign step_last = cmd_q ? CMD_LAST : '0;

  // operation selection for the current step
  always_comb begin
    op_write = wr_q;
    op_addr  = addr_q;
    op_wdata = wdata_q;
    if (cmd_q) begin
      case (step)
        STEP_W'(0): begin
          op_write = 1'b1;
          op_addr  = ADDR_W'(UNLOCK_ADDR_A);
          op_wdata = DATA_W'(UNLOCK_BYTE_A);
        end
        STEP_W'(1): begin
          op_write = 1'b1;
          op_addr  = ADDR_W'(UNLOCK_ADDR_B);
          op_wdata = DATA_W'(UNLOCK_BYTE_B);
        end
        STEP_W'(2): begin
          op_write = 1'b1;
          op_addr  = ADDR_W'(UNLOCK_ADDR_A);
          op_wdata = wdata_q;
        end
        STEP_W'(3): begin
          op_write = 1'b0;
          op_addr  = addr_q;
          op_wdata = wdata_q;
        end
        default: begin
          op_write = 1'b1;
          op_addr  = ADDR_W'(ARRAY_RET_ADDR);
          op_wdata = DATA_W'(ARRAY_RET_BYTE);
        end
      endcase
    end
  end

  assign op_start   = (cst == C_RUN) && !issued && op_idle;
  assign req_ready  = (cst == C_IDLE);
  assign resp_valid = (cst == C_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst       <= C_IDLE;
      issued    <= 1'b0;
      step      <= '0;
      cmd_q     <= 1'b0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      resp_data <= '0;
    end else begin
      case (cst)
        C_IDLE: begin
          if (req_valid) begin
            cmd_q   <= req_cmd;
            wr_q    <= req_write && !req_cmd;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            step    <= '0;
            issued  <= 1'b0;
            cst     <= C_RUN;
          end
        end
        C_RUN: begin
          if (op_start) begin
            issued <= 1'b1;
          end
          if (op_done) begin
            issued <= 1'b0;
            if (!op_write) begin
              resp_data <= op_rdata;
            end
            if (step == step_last) begin
              cst <= wr_q ? C_IDLE : C_RESP;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        C_RESP: begin
          if (resp_ready) begin
            cst <= C_IDLE;
          end
        end
        default: cst <= C_IDLE;
      endcase
    end
  end

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_idle |-> !req_ready);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 2,
  parameter int PULSE_CYC  = 2,
  parameter int ACCESS_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_i,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic              fl_rst_n
);

  logic              op_start;
  logic              op_write;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic              op_idle;
  logic              op_done;
  logic [DATA_W-1:0] op_rdata;
  logic              flash_run_q;

  nor_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_cmd    (req_cmd),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_data  (resp_data),
    .op_start   (op_start),
    .op_write   (op_write),
    .op_addr    (op_addr),
    .op_wdata   (op_wdata),
    .op_idle    (op_idle),
    .op_done    (op_done),
    .op_rdata   (op_rdata)
  );

  nor_op_engine #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SETTLE_CYC (SETTLE_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .ACCESS_CYC (ACCESS_CYC)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_write (op_write),
    .op_addr  (op_addr),
    .op_wdata (op_wdata),
    .op_idle  (op_idle),
    .op_done  (op_done),
    .op_rdata (op_rdata),
    .fl_addr  (fl_addr),
    .fl_dq_o  (fl_dq_o),
    .fl_dq_oe (fl_dq_oe),
    .fl_dq_i  (fl_dq_i),
    .fl_oe_n  (fl_oe_n),
    .fl_we_n  (fl_we_n)
  );

  // flash held out of reset once the system has left reset (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_run_q <= 1'b0;
    end else begin
      flash_run_q <= 1'b1;
    end
  end

  assign fl_rst_n = flash_run_q;
  assign fl_ce_n  = 1'b0;

endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;

  localparam int AW  = 22;
  localparam int DW  = 8;
  localparam int SET = 2;
  localparam int PUL = 2;
  localparam int ACC = 4;
  localparam int LAT_W = SET + PUL + 2;
  localparam int LAT_R = ACC + 1;
  localparam int LAT_C = 4 * LAT_W + LAT_R;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_cmd = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          resp_valid;
  logic          resp_ready = 1'b0;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o;
  logic          fl_dq_oe;
  logic [DW-1:0] fl_dq_i;
  logic          fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n;

  always #10 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(SET), .PULSE_CYC(PUL), .ACCESS_CYC(ACC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_rst_n(fl_rst_n)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural flash stub ----------------
  logic [AW-1:0] sa_prev = '0;
  logic [DW-1:0] sd_prev = '0;
  logic          we_prev = 1'b1;
  int            stable_cyc = 0;
  int            we_high_cyc = 99;
  int            oe_low_cnt = 0;
  logic          id_mode = 1'b0;
  int            unlock_st = 0;
  logic [AW+DW-1:0] wlog[$];
  int            err_settle = 0, err_gap = 0, err_hold = 0, err_order = 0;
  logic [DW-1:0] rd_val;

  assign rd_val  = (id_mode && fl_addr == AW'(2)) ? 8'hF9 : ~fl_addr[7:0];
  assign fl_dq_i = (!fl_oe_n && oe_low_cnt >= ACC - 1) ? rd_val : 8'hEE;

  always @(posedge clk) begin
    if (rst_n) begin
      if (fl_dq_oe && fl_addr == sa_prev && fl_dq_o == sd_prev) stable_cyc = stable_cyc + 1;
      else stable_cyc = 0;
      if (we_prev && !fl_we_n) begin
        if (stable_cyc < SET) err_settle = err_settle + 1;
        if (we_high_cyc < SET) err_gap = err_gap + 1;
      end
      if (!we_prev && fl_we_n) begin
        if (!(fl_dq_oe && fl_addr == sa_prev && fl_dq_o == sd_prev)) err_hold = err_hold + 1;
        wlog.push_back({fl_addr, fl_dq_o});
        if (fl_dq_o == 8'hF0) begin
          id_mode <= 1'b0;
          unlock_st = 0;
        end else if (unlock_st == 0) begin
          if (fl_addr == AW'('hAAA) && fl_dq_o == 8'hAA) unlock_st = 1;
        end else if (unlock_st == 1) begin
          if (fl_addr == AW'('h555) && fl_dq_o == 8'h55) unlock_st = 2;
          else begin err_order = err_order + 1; unlock_st = 0; end
        end else begin
          if (fl_addr == AW'('hAAA)) id_mode <= (fl_dq_o == 8'h90);
          else err_order = err_order + 1;
          unlock_st = 0;
        end
      end
      if (fl_we_n) we_high_cyc = we_high_cyc + 1;
      else we_high_cyc = 0;
      oe_low_cnt <= fl_oe_n ? 0 : oe_low_cnt + 1;
      sa_prev = fl_addr;
      sd_prev = fl_dq_o;
      we_prev = fl_we_n;
    end
  end

  // ---------------- cycle reference model ----------------
  int          m_cnt = 0;
  bit          m_rd = 1'b0;
  bit          m_resp = 1'b0;
  logic [DW-1:0] m_q[$];
  logic [DW-1:0] tb_exp = '0;
  bit          m_ready;
  assign m_ready = (m_cnt == 0) && !m_resp;

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_resp && resp_ready) begin
        m_resp <= 1'b0;
        void'(m_q.pop_front());
      end
      if (req_valid && m_ready) begin
        m_rd  <= req_cmd || !req_write;
        m_cnt <= req_cmd ? LAT_C : (req_write ? LAT_W : LAT_R);
        if (req_cmd || !req_write) m_q.push_back(tb_exp);
      end else if (m_cnt == 1) begin
        m_cnt <= 0;
        if (m_rd) m_resp <= 1'b1;
      end else if (m_cnt > 1) begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(req_ready == m_ready, "R8 req_ready per cycle", req_ready, m_ready);
      chk(resp_valid == m_resp, "R9 resp_valid per cycle", resp_valid, m_resp);
      if (m_resp && resp_valid && m_q.size() > 0)
        chk(resp_data == m_q[0], "R9 resp_data held", resp_data, m_q[0]);
      chk(fl_ce_n == 1'b0 && fl_rst_n == 1'b1, "R1 ce/rst levels", {fl_ce_n, fl_rst_n}, 2'b01);
      chk(!(fl_dq_oe && !fl_oe_n), "R10 bus exclusive", {fl_dq_oe, fl_oe_n}, 2'b01);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic send(input bit wr, input bit cmd, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [DW-1:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cmd = cmd; req_addr = a; req_wdata = d; tb_exp = exp;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(input int hold, input string tag, input logic [DW-1:0] exp);
    while (!resp_valid) @(negedge clk);
    for (int i = 0; i < hold; i++) @(negedge clk);
    chk(resp_data == exp, tag, resp_data, exp);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_log(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    if (idx < wlog.size()) chk(wlog[idx] == {a, d}, tag, wlog[idx], {a, d});
    else chk(1'b0, tag, wlog.size(), idx + 1);
  endtask

  task automatic chk_cmd_log(input int base, input logic [DW-1:0] cb, input string tag);
    chk(wlog.size() == base + 4, {tag, " write count"}, wlog.size(), base + 4);
    chk_log(base + 0, AW'('hAAA), 8'hAA, {tag, " step1"});
    chk_log(base + 1, AW'('h555), 8'h55, {tag, " step2"});
    chk_log(base + 2, AW'('hAAA), cb, {tag, " step3"});
    chk_log(base + 3, AW'(0), 8'hF0, {tag, " array return"});
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && fl_oe_n && fl_we_n && !fl_dq_oe, "R2 reset state",
        {req_ready, resp_valid, fl_oe_n, fl_we_n, fl_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && fl_oe_n && fl_we_n && !fl_dq_oe, "R2 after release",
        {req_ready, resp_valid, fl_oe_n, fl_we_n, fl_dq_oe}, 5'b10110);
    cmp_on = 1'b1;

    // R3 plain reads, low and top address
    send(1'b0, 1'b0, AW'('h00123), 8'h00, 8'hDC);
    collect(0, "R3 read 0x00123", 8'hDC);
    send(1'b0, 1'b0, AW'('h3FFFFF), 8'h00, 8'h00);
    collect(0, "R3 read top address", 8'h00);

    // R4 plain write
    base = wlog.size();
    send(1'b1, 1'b0, AW'('h01234), 8'h5A, 8'h00);
    wait_idle();
    chk(wlog.size() == base + 1, "R4 single write", wlog.size(), base + 1);
    chk_log(base, AW'('h01234), 8'h5A, "R4 write addr/data");

    // R5 identify command
    base = wlog.size();
    send(1'b0, 1'b1, AW'('h002), 8'h90, 8'hF9);
    collect(0, "R5 identifier byte", 8'hF9);
    chk_cmd_log(base, 8'h90, "R5 id sequence");
    send(1'b0, 1'b0, AW'('h002), 8'h00, 8'hFD);
    collect(0, "R5 array mode after command", 8'hFD);

    // R7 command with write flag set
    base = wlog.size();
    send(1'b1, 1'b1, AW'('h002), 8'h90, 8'hF9);
    collect(0, "R7 command ignores write flag", 8'hF9);
    chk_cmd_log(base, 8'h90, "R7 sequence");

    // R5 other command byte: no identify mode
    base = wlog.size();
    send(1'b0, 1'b1, AW'('h002), 8'hA5, 8'hFD);
    collect(0, "R5 non-identify command", 8'hFD);
    chk_cmd_log(base, 8'hA5, "R5 generic sequence");

    // R8/R9 withheld response with a second request queued
    send(1'b0, 1'b1, AW'('h002), 8'h90, 8'hF9);
    fork
      send(1'b0, 1'b0, AW'('h00010), 8'h00, 8'hEF);
      collect(10, "R9 held identifier", 8'hF9);
    join
    collect(0, "R8 queued read after release", 8'hEF);

    wait_idle();
    chk(err_settle == 0, "R4 settle before WE fall", err_settle, 0);
    chk(err_hold == 0, "R4 hold at WE rise", err_hold, 0);
    chk(err_gap == 0, "R6 WE high gap", err_gap, 0);
    chk(err_order == 0, "R5 unlock order", err_order, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule